// File: doc/BRIEF.md
# Wake-up Interrupt Line Controller

This block watches a group of external wake-up lines and merges them into one interrupt request for an interrupt channel that reacts only to rising edges. Each line has a trigger-polarity bit, an enable bit and a pending bit. All three are held in byte-wide registers on a simple write/read bus. A qualifying transition on a line latches that line's pending bit. The request output is the OR of the enabled pending bits. After every write to a pending register the output is held low for a short blanking window, so that a clear which leaves other enabled lines pending presents a fresh rising edge downstream.

The block also guards entry to a low-power halt state. Software must write the halt bit of the control register as 1, then 0, then 1, in three consecutive bus writes. The halt state is taken only if at least one line is enabled and no enabled line is already pending. While halted, a trigger on any enabled line ends the halt and sets a sticky "halt was entered" flag. The pending bit of that line stays set, so software can find the line that woke the device. Software reads back the halt bit and the flag to learn whether the halt really happened, and starts the sequence again if it did not.

The halt sequencer has four states. HS_IDLE goes to HS_ONE on a control write with halt=1. HS_ONE goes to HS_ZERO on a control write with halt=0. It stays in HS_ONE on a control write with halt=1, and returns to HS_IDLE on any other write. HS_ZERO goes to HS_HALT on a control write with halt=1 when the entry condition holds. Any other write, including a control write with halt=1 when the entry condition fails, returns it to HS_IDLE. HS_HALT goes to HS_IDLE on a trigger of an enabled line, and bus writes do not move it.

Top module: `wkup_line_ctrl`

## Requirements
- R1: After reset every register reads 0, and irq_o and stop_o are 0. The register map, for the default of two bytes, is: addresses 0/1 polarity low/high, 2/3 enable low/high, 4/5 pending low/high, and 6 control. Address 7 always reads 0.
- R2: A polarity bit of 1 makes a 0-to-1 transition of its line the trigger, and 0 makes a 1-to-0 transition the trigger. The line's pending bit reads 1 from the second clock edge after the input change. A transition of the other direction leaves the pending bit unchanged.
- R3: A write to a pending byte clears every bit written as 0 and keeps every bit written as 1. A trigger that occurs in the same cycle as the write still sets its bit.
- R4: With routing on, irq_o is 1 exactly when some pending bit has its enable bit set, outside the blanking window. A pending bit whose enable bit is 0 never raises irq_o.
- R5: irq_o is 0 unless control bit 1 (route select) and control bit 2 (request enable) are both 1.
- R6: In the cycle after any write to a pending byte, irq_o is 0. In the next cycle it follows R4 again, so a remaining enabled pending bit produces a new rising edge.
- R7: When no pending bit is set, irq_o is 0.
- R8: Control writes with bit 0 equal to 1, 0, 1 in three consecutive bus writes set stop_o from the cycle after the third write. This needs at least one enable bit set and no enabled pending bit at the time of the third write.
- R9: Any other write between the three control writes returns the sequencer to HS_IDLE. A control write with bit 0 = 1 while waiting for the 0 restarts the sequence as its first step.
- R10: If no enable bit is set, or an enabled pending bit is set, the third write of the sequence leaves stop_o at 0 and the flag at 0.
- R11: While stop_o is 1, a trigger on a line whose enable bit is 0 keeps stop_o at 1. A trigger on an enabled line clears stop_o, sets control bit 7 (the flag) and sets that line's pending bit, all at the same edge.
- R12: A control write with bit 7 = 1 clears the flag. A wake-up in the same cycle wins.
- R13: Reading the control register returns bit 7 = flag, bit 2 = request enable, bit 1 = route select and bit 0 = stop_o. Bits 6:3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 3 | Register address for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| wk_line_i | input | 16 | External wake-up/interrupt lines |
| irq_o | output | 1 | Combined request toward the edge-sensitive interrupt channel |
| stop_o | output | 1 | High while the halt state is held |

## Verification
Each result has a fixed latency. A line transition reaches the pending bit and irq_o at the second clock edge after the input changes. Register writes, the halt transition and the wake-up take effect at the edge that captures the write or the trigger. The blanking low of irq_o occupies exactly the one cycle after a pending write. A behavioural model in the bench advances at each rising edge from the same inputs. The outputs are compared with it five nanoseconds after that edge, never at the edge itself. The directed checks are sampled at the falling edge that follows the edge where the result becomes due. For the blanking requirement they sample that cycle and the next one, to see both the low and the new rising edge.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_ONE  = 2'd1,
        HS_ZERO = 2'd2,
        HS_HALT = 2'd3
    } halt_state_t;

    localparam int CB_HALT = 0;
    localparam int CB_SEL  = 1;
    localparam int CB_EN   = 2;
    localparam int CB_FLAG = 7;

endpackage

// File: rtl/wkup_trig_bank.sv
module wkup_trig_bank #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    input  logic [LINES-1:0] pol_i,
    output logic [LINES-1:0] trig_o
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic cur_q;
        logic old_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q <= 1'b0;
                old_q <= 1'b0;
            end else begin
                cur_q <= line_i[i];
                old_q <= cur_q;
            end
        end

        // polarity 1: low-to-high counts, polarity 0: high-to-low counts
        assign trig_o[i] = pol_i[i] ? (cur_q & ~old_q) : (~cur_q & old_q);
    end

endmodule

// File: rtl/wkup_halt_fsm.sv
module wkup_halt_fsm
    import wkup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic other_wr,
    input  logic halt_bit,
    input  logic any_en,
    input  logic req_pend,
    input  logic wake,
    output logic halt_o,
    output logic woke_o
);

    halt_state_t st_q;
    halt_state_t st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            HS_IDLE: begin
                if (ctrl_wr && halt_bit) st_nxt = HS_ONE;
            end
            HS_ONE: begin
                if (ctrl_wr)       st_nxt = halt_bit ? HS_ONE : HS_ZERO;
                else if (other_wr) st_nxt = HS_IDLE;
            end
            HS_ZERO: begin
                if (ctrl_wr && halt_bit && any_en && !req_pend) st_nxt = HS_HALT;
                else if (ctrl_wr || other_wr)                  st_nxt = HS_IDLE;
            end
            HS_HALT: begin
                if (wake) st_nxt = HS_IDLE;
            end
            default: st_nxt = HS_IDLE;
        endcase
    end

    always_comb begin
        halt_o = (st_q == HS_HALT);
        woke_o = (st_q == HS_HALT) && wake;
    end

endmodule

// File: rtl/wkup_req_shaper.sv
module wkup_req_shaper #(
    parameter int BLANK_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_wr,
    input  logic req_lvl,
    input  logic route_ok,
    output logic irq_o
);

    localparam int CW = $clog2(BLANK_CYC + 1);

    logic [CW-1:0] blank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            blank_q <= '0;
        else if (pend_wr)      blank_q <= CW'(BLANK_CYC);
        else if (blank_q != 0) blank_q <= blank_q - 1'b1;
    end

    assign irq_o = route_ok && (blank_q == 0) && req_lvl;

endmodule

// File: rtl/wkup_line_ctrl.sv
module wkup_line_ctrl
    import wkup_pkg::*;
#(
    parameter int NBYTES    = 2,
    parameter int BLANK_CYC = 1,
    localparam int LINES    = 8 * NBYTES,
    localparam int NREG     = 3 * NBYTES + 1,
    localparam int AW       = $clog2(NREG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [LINES-1:0] wk_line_i,
    output logic             irq_o,
    output logic             stop_o
);

    localparam int POL_BASE = 0;
    localparam int MSK_BASE = NBYTES;
    localparam int PND_BASE = 2 * NBYTES;
    localparam int CTL_ADDR = 3 * NBYTES;

    logic [LINES-1:0]  pol_q, msk_q, pnd_q;
    logic              sel_q, en_q, flag_q;
    logic [LINES-1:0]  trig;
    logic [LINES-1:0]  pol_bits, msk_bits, pnd_keep;
    logic [NBYTES-1:0] pnd_hit;
    logic [LINES-1:0]  wdata_rep;
    logic              ctl_hit, other_wr, woke, halt;

    assign wdata_rep = {NBYTES{bus_wdata}};
    assign ctl_hit   = bus_we && (bus_addr == AW'(CTL_ADDR));
    assign other_wr  = bus_we && !ctl_hit;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic pol_hit, msk_hit;
        assign pol_hit    = bus_we && (bus_addr == AW'(POL_BASE + b));
        assign msk_hit    = bus_we && (bus_addr == AW'(MSK_BASE + b));
        assign pnd_hit[b] = bus_we && (bus_addr == AW'(PND_BASE + b));
        assign pol_bits[8*b +: 8] = {8{pol_hit}};
        assign msk_bits[8*b +: 8] = {8{msk_hit}};
        assign pnd_keep[8*b +: 8] = pnd_hit[b] ? bus_wdata : 8'hFF;
    end

    wkup_trig_bank #(.LINES(LINES)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (wk_line_i),
        .pol_i  (pol_q),
        .trig_o (trig)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= '0;
            msk_q  <= '0;
            pnd_q  <= '0;
            sel_q  <= 1'b0;
            en_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pol_q  <= (pol_q & ~pol_bits) | (wdata_rep & pol_bits);
            msk_q  <= (msk_q & ~msk_bits) | (wdata_rep & msk_bits);
            pnd_q  <= (pnd_q & pnd_keep) | trig;
            if (ctl_hit) begin
                sel_q <= bus_wdata[CB_SEL];
                en_q  <= bus_wdata[CB_EN];
            end
            flag_q <= woke | (flag_q & ~(ctl_hit & bus_wdata[CB_FLAG]));
        end
    end

    wkup_halt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctl_hit),
        .other_wr (other_wr),
        .halt_bit (bus_wdata[CB_HALT]),
        .any_en   (|msk_q),
        .req_pend (|(pnd_q & msk_q)),
        .wake     (|(trig & msk_q)),
        .halt_o   (halt),
        .woke_o   (woke)
    );

    wkup_req_shaper #(.BLANK_CYC(BLANK_CYC)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_wr  (|pnd_hit),
        .req_lvl  (|(pnd_q & msk_q)),
        .route_ok (sel_q && en_q),
        .irq_o    (irq_o)
    );

    assign stop_o = halt;

    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < NBYTES; i++) begin
            if (bus_addr == AW'(POL_BASE + i)) bus_rdata = pol_q[8*i +: 8];
            if (bus_addr == AW'(MSK_BASE + i)) bus_rdata = msk_q[8*i +: 8];
            if (bus_addr == AW'(PND_BASE + i)) bus_rdata = pnd_q[8*i +: 8];
        end
        if (bus_addr == AW'(CTL_ADDR)) begin
            bus_rdata[CB_HALT] = halt;
            bus_rdata[CB_SEL]  = sel_q;
            bus_rdata[CB_EN]   = en_q;
            bus_rdata[CB_FLAG] = flag_q;
        end
    end

endmodule

// File: rtl/wkup_line_ctrl_chk.sv
module wkup_line_ctrl_chk #(
    parameter int LINES    = 16,
    parameter int AW       = 3,
    parameter int PND_BASE = 4,
    parameter int CTL_ADDR = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             irq_o,
    input logic             stop_o,
    input logic [LINES-1:0] pnd_q,
    input logic [LINES-1:0] msk_q,
    input logic [LINES-1:0] trig,
    input logic             flag_q
);

    // R3
    trig_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig != 0) |=> ((pnd_q & $past(trig)) == $past(trig)));

    // R6
    blank_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) >= PND_BASE && int'(bus_addr) < CTL_ADDR) |=> !irq_o);

    // R7
    no_pending_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pnd_q == 0) |-> !irq_o);

    // R8
    halt_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_o) |-> $past(bus_we && int'(bus_addr) == CTL_ADDR && bus_wdata[0]));

    // R10
    halt_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == CTL_ADDR && bus_wdata[0] && msk_q == 0 && !stop_o)
        |=> !stop_o);

    // R11
    halt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && (trig & msk_q) == 0) |=> stop_o);

    // R11
    wake_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_o) |-> flag_q);

endmodule

bind wkup_line_ctrl wkup_line_ctrl_chk #(
    .LINES    (LINES),
    .AW       (AW),
    .PND_BASE (2 * NBYTES),
    .CTL_ADDR (3 * NBYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .stop_o    (stop_o),
    .pnd_q     (pnd_q),
    .msk_q     (msk_q),
    .trig      (trig),
    .flag_q    (flag_q)
);

// File: tb/wkup_line_ctrl_tb.sv
module wkup_line_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [15:0] wk_line = 16'h0000;
    logic        irq_o, stop_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wkup_line_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wk_line_i (wk_line),
        .irq_o     (irq_o),
        .stop_o    (stop_o)
    );

    // behavioural reference model
    logic [15:0] m_pol, m_msk, m_pnd, m_s1, m_s2;
    bit m_sel, m_en, m_flag, m_blank;
    int m_st; // 0 idle, 1 saw one, 2 saw one-zero, 3 halted

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pol = 0; m_msk = 0; m_pnd = 0; m_s1 = 0; m_s2 = 0;
            m_sel = 0; m_en = 0; m_flag = 0; m_blank = 0; m_st = 0;
        end else begin
            logic [15:0] tr;
            bit wake, reqp, anyen;
            tr = 0;
            for (int i = 0; i < 16; i++) begin
                if (m_pol[i]) tr[i] = m_s1[i] && !m_s2[i];
                else          tr[i] = !m_s1[i] && m_s2[i];
            end
            wake  = (m_st == 3) && ((tr & m_msk) != 0);
            reqp  = (m_pnd & m_msk) != 0;
            anyen = m_msk != 0;
            m_blank = 0;
            if (bus_we) begin
                case (bus_addr)
                    3'd0: m_pol[7:0]  = bus_wdata;
                    3'd1: m_pol[15:8] = bus_wdata;
                    3'd2: m_msk[7:0]  = bus_wdata;
                    3'd3: m_msk[15:8] = bus_wdata;
                    3'd4: begin m_pnd[7:0]  = m_pnd[7:0]  & bus_wdata; m_blank = 1; end
                    3'd5: begin m_pnd[15:8] = m_pnd[15:8] & bus_wdata; m_blank = 1; end
                    3'd6: begin
                        m_sel = bus_wdata[1];
                        m_en  = bus_wdata[2];
                        if (bus_wdata[7]) m_flag = 0;
                    end
                    default: ;
                endcase
            end
            m_pnd = m_pnd | tr;
            if (m_st == 3) begin
                if (wake) m_st = 0;
            end else if (bus_we) begin
                if (bus_addr == 3'd6) begin
                    case (m_st)
                        0: m_st = bus_wdata[0] ? 1 : 0;
                        1: m_st = bus_wdata[0] ? 1 : 2;
                        default: m_st = (bus_wdata[0] && anyen && !reqp) ? 3 : 0;
                    endcase
                end else begin
                    m_st = 0;
                end
            end
            if (wake) m_flag = 1;
            m_s2 = m_s1;
            m_s1 = wk_line;
        end
    end

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_pol[7:0];
            3'd1: return m_pol[15:8];
            3'd2: return m_msk[7:0];
            3'd3: return m_msk[15:8];
            3'd4: return m_pnd[7:0];
            3'd5: return m_pnd[15:8];
            3'd6: return {m_flag, 4'b0, m_en, m_sel, (m_st == 3)};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, 5 ns after each rising edge
    always begin
        @(posedge clk);
        #5;
        if (rst_n && !done) begin
            chk("R6 irq_o vs model", {7'b0, irq_o},
                {7'b0, m_sel && m_en && !m_blank && ((m_pnd & m_msk) != 0)});
            chk("R8 stop_o vs model", {7'b0, stop_o}, {7'b0, m_st == 3});
            chk("R13 bus_rdata vs model", bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk);
        wk_line[i] = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_o after reset", {7'b0, irq_o}, 8'h00);
        chk("R1 stop_o after reset", {7'b0, stop_o}, 8'h00);
        rd(3'd6, v); chk("R1 control after reset", v, 8'h00);
        rd(3'd4, v); chk("R1 pending after reset", v, 8'h00);
        rd(3'd7, v); chk("R1 unmapped address", v, 8'h00);

        wr(3'd0, 8'h0F);
        wr(3'd2, 8'h03);
        wr(3'd6, 8'h06);
        rd(3'd6, v); chk("R13 control readback", v, 8'h06);

        set_line(0, 1'b1);
        rd(3'd4, v); chk("R2 rising trigger sets pending", v, 8'h01);
        chk("R4 enabled pending raises irq", {7'b0, irq_o}, 8'h01);
        set_line(4, 1'b1);
        rd(3'd4, v); chk("R2 wrong direction ignored", v, 8'h01);
        set_line(4, 1'b0);
        rd(3'd4, v); chk("R2 falling trigger sets pending", v, 8'h11);

        wr(3'd4, 8'hFE);
        rd(3'd4, v); chk("R3 zero bit clears pending", v, 8'h10);
        repeat (2) @(negedge clk);
        chk("R4 disabled pending gives no irq", {7'b0, irq_o}, 8'h00);

        set_line(1, 1'b1);
        chk("R4 second line raises irq", {7'b0, irq_o}, 8'h01);
        wr(3'd6, 8'h02);
        chk("R5 request enable off blocks irq", {7'b0, irq_o}, 8'h00);
        wr(3'd6, 8'h06);
        chk("R5 routing restored", {7'b0, irq_o}, 8'h01);

        set_line(0, 1'b0);
        set_line(0, 1'b1);
        wr(3'd4, 8'hFD);
        chk("R6 blank cycle after clear", {7'b0, irq_o}, 8'h00);
        @(negedge clk);
        chk("R6 new rising edge", {7'b0, irq_o}, 8'h01);
        rd(3'd4, v); chk("R3 partial clear", v, 8'h11);
        wr(3'd4, 8'hFF);
        rd(3'd4, v); chk("R3 one bits keep pending", v, 8'h11);

        wr(3'd4, 8'h00);
        chk("R7 blank after full clear", {7'b0, irq_o}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R7 no edge after full clear", {7'b0, irq_o}, 8'h00);

        wr(3'd2, 8'h00);
        wr(3'd6, 8'h07); wr(3'd6, 8'h06); wr(3'd6, 8'h07);
        chk("R10 no enabled line refuses halt", {7'b0, stop_o}, 8'h00);
        rd(3'd6, v); chk("R10 flag stays clear", v, 8'h06);

        wr(3'd2, 8'h03);
        wr(3'd6, 8'h07); wr(3'd6, 8'h06); wr(3'd0, 8'h0F); wr(3'd6, 8'h07);
        chk("R9 interrupted sequence", {7'b0, stop_o}, 8'h00);
        wr(3'd6, 8'h07); wr(3'd6, 8'h06); wr(3'd6, 8'h07);
        chk("R8 one-zero-one enters halt", {7'b0, stop_o}, 8'h01);
        rd(3'd6, v); chk("R13 halt bit readback", v, 8'h07);

        set_line(4, 1'b1);
        set_line(4, 1'b0);
        chk("R11 disabled line keeps halt", {7'b0, stop_o}, 8'h01);
        set_line(1, 1'b0);
        set_line(1, 1'b1);
        chk("R11 enabled line wakes", {7'b0, stop_o}, 8'h00);
        rd(3'd6, v); chk("R11 flag set on wake", v, 8'h86);
        rd(3'd4, v); chk("R11 waking line stays pending", v, 8'h12);

        wr(3'd6, 8'h86);
        rd(3'd6, v); chk("R12 flag cleared", v, 8'h06);

        wr(3'd1, 8'hFF);
        wr(3'd3, 8'h01);
        set_line(8, 1'b1);
        rd(3'd5, v); chk("R2 high byte line", v, 8'h01);

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule